// File: doc/BRIEF.md
# ADC channel-list acquisition controller

This block sequences conversions for a 16-input multiplexed ADC front end behind a 16-bit register bus. The host fills a channel-list store with 8-bit entries, picks a trigger source in the first control word, and enables the two queues in the second control word. Each accepted trigger hands the next list entry to the converter through a request/done handshake. The returned 12-bit sample goes into a result queue, and the host drains that queue by reading the data address.

A state machine with four states does the sequencing. `SEQ_IDLE` moves to `SEQ_ARMED` once a trigger source is selected, the list is enabled and the list holds at least one entry. `SEQ_ARMED` moves to `SEQ_CONV` on a trigger. `SEQ_CONV` holds the request until the converter answers. It then returns to `SEQ_ARMED` in two cases: more entries remain, or continuous mode wraps the list pointer back to entry 0. After the final entry of a single pass it moves to `SEQ_DONE`. Every state falls back to `SEQ_IDLE` when the trigger source is set to off or the list is disabled.

The block also provides status flags, a half-full interrupt with a pending flag, and a strobe that clears the pending flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A synchronous reset clears both control words, both queues and the pending flag. After reset the status word (offset 0x04) reads 0x0004, `irq` is 0 and `conv_req` is 0.
- R2: Control word 1 (offset 0x00) bits [1:0] pick the trigger source: 0 off, 1 software, 2 scan tick, 3 external edge. With the source set to off, no trigger starts a conversion.
- R3: In software mode, a bus read of offset 0x00 while armed starts exactly one conversion. `conv_req` stays high until `conv_done` arrives. `conv_cfg` carries the current list entry unchanged.
- R4: In scan mode each `scan_tick` pulse starts one conversion. In external mode a rising edge of `ext_trig` starts one, or a falling edge when control word 1 bit 3 is set. The opposite edge and the other sources' triggers are ignored.
- R5: A bus write to offset 0x10 appends `bus_wdata[7:0]` to the channel list. The entry fields are channel [3:0], gain [5:4], unipolar [6] and differential [7]. The list holds LIST_DEPTH entries, and writes while it is full are dropped.
- R6: A bus read of offset 0x10 pops the oldest result and returns it in bits [11:0] with the upper bits zero. An empty queue reads 0 and is not disturbed.
- R7: The status word carries these bits: 0 = sequencer armed or converting, 1 = list full, 2 = results empty, 3 = results half full, 4 = results full, 8 = interrupt pending.
- R8: Control word 2 (offset 0x02) bit 10 enables the result queue and bit 9 enables the list. While a bit is 0, its queue is emptied and held empty. Disabling the list returns the sequencer to `SEQ_IDLE`.
- R9: With control word 1 bit 2 clear, the sequencer stops in `SEQ_DONE` after the last list entry and further triggers are ignored until the source is set to off. With bit 2 set, the list pointer wraps to entry 0.
- R10: The result queue holds RES_DEPTH samples. Half full means at least RES_DEPTH/2 samples. A result arriving while the queue is full is dropped.
- R11: The pending flag sets when control word 1 bit 8 is 1 and the result count reaches the half-full level. `irq` equals pending AND control word 1 bit 15. Any write to offset 0x04 clears pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| ext_trig | input | 1 | External trigger level |
| scan_tick | input | 1 | Scan timer pulse |
| conv_req | output | 1 | Conversion request to the converter |
| conv_cfg | output | 8 | List entry for the requested conversion |
| conv_done | input | 1 | Converter completion pulse |
| conv_sample | input | SAMPLE_W | Converted sample, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16 list entries and 16 result slots. At this depth a full list, a full result queue and the half-full threshold all lie within a few dozen conversions. That makes it practical to sweep every list length from 1 to 16 in single-pass mode and to check the pass length, the stopping point and each sample's tag at every length. The bench's converter tags each sample with the entry it received and a running count, so the list order, continuous-mode wrap, dropped results and all four trigger sources are checked arithmetically against those tags.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BUS_W   = 16;
    localparam int ENTRY_W = 8;

    localparam int OFF_CTRL1  = 'h00;
    localparam int OFF_CTRL2  = 'h02;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_DATA   = 'h10;

    localparam int C1_CONT   = 2;
    localparam int C1_FALL   = 3;
    localparam int C1_HIE    = 8;
    localparam int C1_GIE    = 15;
    localparam int C2_LISTEN = 9;
    localparam int C2_RESEN  = 10;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_SW   = 2'd1,
        TRIG_SCAN = 2'd2,
        TRIG_EXT  = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_CONV  = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       falling,
    input  logic       sw_start,
    input  logic       scan_tick,
    input  logic       ext_trig,
    output logic       trig_fire
);

    logic ext_q;
    logic ext_rise;
    logic ext_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_trig;
        end
    end

    assign ext_rise = ext_trig && !ext_q;
    assign ext_fall = !ext_trig && ext_q;

    always_comb begin
        unique case (mode)
            TRIG_OFF:  trig_fire = 1'b0;
            TRIG_SW:   trig_fire = sw_start;
            TRIG_SCAN: trig_fire = scan_tick;
            TRIG_EXT:  trig_fire = falling ? ext_fall : ext_rise;
        endcase
    end

    // R4: an edge in external mode needs the level to have moved since the last cycle
    a_r4_ext_edge_moved: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EXT && trig_fire) |-> (ext_trig != ext_q));

endmodule

// File: rtl/adc_list_store.sv
module adc_list_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       wr_en,
    input  logic [ENTRY_W-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [ENTRY_W-1:0]         rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);

    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic               do_wr;

    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && enable && !full;
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            count <= '0;
        end else if (do_wr) begin
            count <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (do_wr) begin
            mem[IW'(count)] <= wr_data;
        end
    end

    // R5: a write into a full list leaves it full, with nothing overwritten
    a_r5_list_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && enable) |=> full);

    // R8: a disabled list is empty one cycle later
    a_r8_list_held_empty: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (count == '0));

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       half,
    output logic                       full
);

    localparam int PW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign half    = (count >= CW'(HALF));
    assign do_push = push && enable && !full;
    assign do_pop  = pop && enable && !empty;
    assign head    = empty ? '0 : mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= bump(wptr);
            end
            if (do_pop) begin
                rptr <= bump(rptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    // R10: a result arriving at a full queue is dropped
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && enable) |=> full);

    // R6: popping an empty queue leaves it empty
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int LIST_DEPTH = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  trig_mode_e                      mode,
    input  logic                            continuous,
    input  logic                            list_en,
    input  logic [$clog2(LIST_DEPTH+1)-1:0] list_count,
    input  logic                            trig,
    input  logic                            conv_done,
    output logic [$clog2(LIST_DEPTH)-1:0]   rd_idx,
    output logic                            conv_req,
    output logic                            active,
    output logic                            store
);

    localparam int PW = $clog2(LIST_DEPTH);
    localparam int CW = $clog2(LIST_DEPTH + 1);

    seq_state_e    state;
    seq_state_e    state_n;
    logic [PW-1:0] ptr;
    logic          run_ok;
    logic          last;

    assign run_ok = (mode != TRIG_OFF) && list_en;
    assign last   = (CW'(ptr) == (list_count - CW'(1)));
    assign rd_idx = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            SEQ_IDLE: begin
                if (run_ok && list_count != '0) state_n = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (!run_ok)   state_n = SEQ_IDLE;
                else if (trig) state_n = SEQ_CONV;
            end
            SEQ_CONV: begin
                if (!run_ok) begin
                    state_n = SEQ_IDLE;
                end else if (conv_done) begin
                    state_n = (last && !continuous) ? SEQ_DONE : SEQ_ARMED;
                end
            end
            SEQ_DONE: begin
                if (!run_ok) state_n = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || state == SEQ_IDLE) begin
            ptr <= '0;
        end else if (state == SEQ_CONV && conv_done && run_ok) begin
            ptr <= last ? '0 : ptr + PW'(1);
        end
    end

    always_comb begin
        conv_req = 1'b0;
        active   = 1'b0;
        store    = 1'b0;
        unique case (state)
            SEQ_IDLE:  ;
            SEQ_ARMED: active = 1'b1;
            SEQ_CONV: begin
                active   = 1'b1;
                conv_req = 1'b1;
                store    = conv_done && run_ok;
            end
            SEQ_DONE:  ;
        endcase
    end

    // R2: with the source off, no request is raised on the next cycle
    a_r2_off_no_req: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_OFF) |=> !conv_req);

    // R3: a request is held until the converter answers
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done && run_ok) |=> conv_req);

    // R9: a single pass stops after its last entry
    a_r9_single_stop: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CONV && conv_done && run_ok && last && !continuous) |=> !active);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int LIST_DEPTH = 16,
    parameter int RES_DEPTH  = 16,
    parameter int SAMPLE_W   = 12,
    parameter int ADDR_W     = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                ext_trig,
    input  logic                scan_tick,
    output logic                conv_req,
    output logic [ENTRY_W-1:0]  conv_cfg,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_sample,
    output logic                irq
);

    localparam int LIW = $clog2(LIST_DEPTH);
    localparam int LCW = $clog2(LIST_DEPTH + 1);
    localparam int RCW = $clog2(RES_DEPTH + 1);

    logic [BUS_W-1:0]    ctrl1;
    logic [BUS_W-1:0]    ctrl2;
    logic                pend;
    logic                half_q;
    trig_mode_e          mode;
    logic                sel_c1, sel_c2, sel_st, sel_dat;
    logic                sw_start;
    logic                trig_fire;
    logic [LIW-1:0]      rd_idx;
    logic [LCW-1:0]      list_count;
    logic                list_full;
    logic                active;
    logic                store;
    logic [SAMPLE_W-1:0] res_head;
    logic [RCW-1:0]      res_count;
    logic                res_empty, res_half, res_full;
    logic [BUS_W-1:0]    status;

    assign mode    = trig_mode_e'(ctrl1[1:0]);
    assign sel_c1  = (bus_addr == ADDR_W'(OFF_CTRL1));
    assign sel_c2  = (bus_addr == ADDR_W'(OFF_CTRL2));
    assign sel_st  = (bus_addr == ADDR_W'(OFF_STATUS));
    assign sel_dat = (bus_addr == ADDR_W'(OFF_DATA));
    assign sw_start = bus_rd && sel_c1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl1 <= '0;
            ctrl2 <= '0;
        end else if (bus_wr) begin
            if (sel_c1) ctrl1 <= bus_wdata;
            if (sel_c2) ctrl2 <= bus_wdata;
        end
    end

    adc_trig_detect u_trig (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .falling   (ctrl1[C1_FALL]),
        .sw_start  (sw_start),
        .scan_tick (scan_tick),
        .ext_trig  (ext_trig),
        .trig_fire (trig_fire)
    );

    adc_list_store #(.DEPTH(LIST_DEPTH), .ENTRY_W(ENTRY_W)) u_list (
        .clk     (clk),
        .rst     (rst),
        .enable  (ctrl2[C2_LISTEN]),
        .wr_en   (bus_wr && sel_dat),
        .wr_data (bus_wdata[ENTRY_W-1:0]),
        .rd_idx  (rd_idx),
        .rd_data (conv_cfg),
        .count   (list_count),
        .full    (list_full)
    );

    adc_seq_fsm #(.LIST_DEPTH(LIST_DEPTH)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .continuous (ctrl1[C1_CONT]),
        .list_en    (ctrl2[C2_LISTEN]),
        .list_count (list_count),
        .trig       (trig_fire),
        .conv_done  (conv_done),
        .rd_idx     (rd_idx),
        .conv_req   (conv_req),
        .active     (active),
        .store      (store)
    );

    adc_result_fifo #(.DEPTH(RES_DEPTH), .WIDTH(SAMPLE_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl2[C2_RESEN]),
        .push      (store),
        .push_data (conv_sample),
        .pop       (bus_rd && sel_dat),
        .head      (res_head),
        .count     (res_count),
        .empty     (res_empty),
        .half      (res_half),
        .full      (res_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            half_q <= res_half;
            if (bus_wr && sel_st) begin
                pend <= 1'b0;
            end else if (ctrl1[C1_HIE] && res_half && !half_q) begin
                pend <= 1'b1;
            end
        end
    end

    assign irq = pend && ctrl1[C1_GIE];

    always_comb begin
        status    = '0;
        status[0] = active;
        status[1] = list_full;
        status[2] = res_empty;
        status[3] = res_half;
        status[4] = res_full;
        status[8] = pend;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_st) begin
            bus_rdata = status;
        end else if (sel_dat) begin
            bus_rdata = BUS_W'(res_head);
        end
    end

    // R11: a clear write leaves nothing pending on the next cycle
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_st) |=> !pend);

    // R11: pending only rises while the half-full interrupt is enabled
    a_r11_set_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(ctrl1[C1_HIE]));

    // R8: a disabled result queue reads empty one cycle later
    a_r8_res_flush: assert property (@(posedge clk) disable iff (rst)
        !ctrl2[C2_RESEN] |=> res_empty);

    // R10: the count never exceeds the depth
    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        res_count <= RCW'(RES_DEPTH));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        scan_tick = 1'b0;
    logic        conv_req;
    logic [7:0]  conv_cfg;
    logic        conv_done = 1'b0;
    logic [11:0] conv_sample = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int conv_idx = 0;
    logic [7:0] lst [17];

    always #10 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
        .scan_tick(scan_tick), .conv_req(conv_req), .conv_cfg(conv_cfg),
        .conv_done(conv_done), .conv_sample(conv_sample), .irq(irq)
    );

    // converter model: answers one cycle after a request, tags each sample
    always @(negedge clk) begin
        if (conv_req && !conv_done) begin
            conv_done   = 1'b1;
            conv_sample = {conv_cfg, 4'(conv_idx)};
            conv_idx    = conv_idx + 1;
        end else begin
            conv_done = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic sw_trig();
        logic [15:0] d;
        rd(6'h00, d);
        tick(3);
    endtask

    task automatic set_mode(input logic [15:0] v);
        wr(6'h00, v);
        tick(1);
    endtask

    task automatic flush();
        wr(6'h00, 16'h0000);
        wr(6'h02, 16'h0000);
        wr(6'h02, 16'h0600);
    endtask

    task automatic expect_status(input string req, input logic [15:0] exp);
        logic [15:0] d;
        rd(6'h04, d);
        chk(req, d, exp);
    endtask

    task automatic expect_sample(input string req, input logic [15:0] exp);
        logic [15:0] d;
        rd(6'h10, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        logic [15:0] d;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        expect_status("R1 status after reset", 16'h0004);
        chk("R1 irq after reset", 16'(irq), 16'h0000);
        chk("R1 conv_req after reset", 16'(conv_req), 16'h0000);

        // R2: source off ignores a start read
        flush();
        wr(6'h10, 16'h0001);
        sw_trig();
        expect_status("R2 off ignores start", 16'h0004);

        // R9 R5 R3 R6: sweep of every list length in single-pass mode
        for (int len = 1; len <= 16; len++) begin
            flush();
            for (int i = 0; i < len; i++) begin
                lst[i] = 8'((len * 37 + i * 11) & 8'hFF);
                wr(6'h10, {8'h00, lst[i]});
            end
            if (len == 16) wr(6'h10, 16'h00FF); // R5: dropped, list full
            set_mode(16'h0001);
            base = conv_idx;
            for (int i = 0; i < len; i++) sw_trig();
            rd(6'h04, d);
            chk("R9 single pass inactive", 16'(d[0]), 16'h0000);
            chk("R5 list full flag", 16'(d[1]), (len == 16) ? 16'h0001 : 16'h0000);
            sw_trig(); // R9: ignored after the pass
            for (int i = 0; i < len; i++)
                expect_sample("R3 R6 sample order", {4'h0, lst[i], 4'(base + i)});
            expect_sample("R6 empty read is zero", 16'h0000);
            expect_status("R9 no extra conversion", (len == 16) ? 16'h0006 : 16'h0004);
        end

        // R10 R7: overflow in continuous mode with wrap
        flush();
        lst[0] = 8'h12; lst[1] = 8'h34;
        wr(6'h10, 16'h0012);
        wr(6'h10, 16'h0034);
        set_mode(16'h0005);
        base = conv_idx;
        for (int i = 0; i < 20; i++) sw_trig();
        expect_status("R10 R7 full status", 16'h0019);
        for (int k = 0; k < 16; k++)
            expect_sample("R10 R9 wrap and drop", {4'h0, lst[k % 2], 4'(base + k)});
        expect_status("R7 armed and empty", 16'h0005);

        // R11: half-full interrupt
        flush();
        wr(6'h10, 16'h005A);
        set_mode(16'h0105);
        for (int i = 0; i < 7; i++) sw_trig();
        expect_status("R11 below half", 16'h0001);
        sw_trig();
        expect_status("R11 pending at half", 16'h0109);
        chk("R11 irq gated off", 16'(irq), 16'h0000);
        wr(6'h00, 16'h8105);
        tick(1);
        chk("R11 irq enabled", 16'(irq), 16'h0001);
        wr(6'h04, 16'h0000);
        chk("R11 irq cleared", 16'(irq), 16'h0000);
        expect_status("R11 pending cleared", 16'h0009);

        // R4: scan tick, software read ignored in scan mode
        flush();
        lst[0] = 8'h81; lst[1] = 8'h42;
        wr(6'h10, 16'h0081);
        wr(6'h10, 16'h0042);
        set_mode(16'h0006);
        base = conv_idx;
        sw_trig();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) scan_tick = 1'b1;
            @(negedge clk) scan_tick = 1'b0;
            tick(3);
        end
        for (int k = 0; k < 3; k++)
            expect_sample("R4 scan samples", {4'h0, lst[k % 2], 4'(base + k)});
        expect_sample("R4 scan count", 16'h0000);

        // R4: external rising, then falling
        flush();
        wr(6'h10, 16'h00C3);
        set_mode(16'h0007);
        base = conv_idx;
        @(negedge clk) ext_trig = 1'b1;
        tick(4);
        @(negedge clk) ext_trig = 1'b0;
        tick(4);
        expect_sample("R4 rising edge", {4'h0, 8'hC3, 4'(base)});
        expect_sample("R4 falling ignored", 16'h0000);
        set_mode(16'h000F);
        base = conv_idx;
        @(negedge clk) ext_trig = 1'b1;
        tick(4);
        @(negedge clk) ext_trig = 1'b0;
        tick(4);
        expect_sample("R4 falling edge", {4'h0, 8'hC3, 4'(base)});
        expect_sample("R4 rising ignored", 16'h0000);

        // R8: disabling the list and the result queue
        flush();
        wr(6'h10, 16'h0011);
        set_mode(16'h0005);
        sw_trig();
        expect_status("R8 one result armed", 16'h0001);
        wr(6'h02, 16'h0200);
        tick(1);
        expect_status("R8 result flushed", 16'h0005);
        wr(6'h02, 16'h0400);
        tick(1);
        expect_status("R8 list off idles", 16'h0004);
        sw_trig();
        expect_status("R8 no conversion", 16'h0004);

        // R1: reset mid-run
        wr(6'h02, 16'h0600);
        wr(6'h10, 16'h0022);
        set_mode(16'h8105);
        sw_trig();
        @(negedge clk) rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        expect_status("R1 status after reset", 16'h0004);
        sw_trig();
        expect_status("R1 controls cleared", 16'h0004);
        chk("R1 irq low", 16'(irq), 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule